// File: doc/BRIEF.md
# I2C Target Register Pointer with Auto-Increment

This block is the byte-level target side of a two-wire serial interface that fronts a small LED controller register file. A bit-level engine, outside this block, detects start and stop conditions, shifts bytes in and out, and asks this block whether to acknowledge each byte it receives and what to put on the bus for each byte it sends. The block matches the fixed 7-bit target address, takes the direction from the last address bit and steers the data bytes that follow onto a simple register-file port.

In a write transfer, the first byte after the address is the control byte. Its low three bits point at a register, and bit 4 turns auto-increment on. Further write bytes go to the selected register. A read transfer returns the selected register. With auto-increment on, the pointer steps after every data byte and wraps from 7 to 0, and the control byte's other bits stay as they are. The register map has six locations. Index 0 is the read-only input register, and indices 1 to 5 can be written. Indices 6 and 7 read as zero, drop writes and still count in the wrap. A repeated start keeps the pointer, so a master can set the pointer in a write and then read from it without a stop in between.

Top module: `i2c_ptr_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 7'b1100010 (with `VARIANT`=0) or 7'b1100011 (with `VARIANT`=1). `ack_o` is high only in a cycle where `rx_valid_i` is high.
- R2: Address bit 0 sets the direction. A value of 1 starts a read, in which each `tx_req_i` is served from `tx_data_o`. A value of 0 starts a write, in which the received bytes are acknowledged.
- R3: The first byte after an acknowledged write address loads the control register and causes no register-file write. Bits [2:0] form the pointer and bit 4 is the auto-increment flag.
- R4: Every later write byte is acknowledged. It appears on `rf_wdata_o` with `rf_we_o` high and `rf_addr_o` equal to the pointer, but only when the pointer is between 1 and 5. Index 0 is read-only.
- R5: With auto-increment set, the pointer advances by one after each data byte, written or read. It wraps from 7 to 0, and indices 6 and 7 are visited on the way.
- R6: Auto-increment changes only control bits [2:0]. Bits [7:3], including the flag, keep their value until the next control byte.
- R7: After reset the control register is 00h: the pointer is 0 and auto-increment is off.
- R8: With the pointer at 6 or 7, `tx_data_o` reads 00h and write bytes do not assert `rf_we_o`.
- R9: A read that begins with auto-increment set and the pointer at 0 leaves the pointer at 0 for that whole read. Every byte returns the input register.
- R10: After an address byte that does not match, the block acknowledges nothing and writes nothing until the next start.
- R11: A repeated start keeps the pointer, so a read after a control-byte write begins at the newly set index.
- R12: With auto-increment clear, the pointer stays fixed across data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen, one-cycle pulse |
| stop_i | input | 1 | Stop seen, one-cycle pulse |
| rx_valid_i | input | 1 | Received byte valid, one-cycle pulse |
| rx_data_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the byte in this cycle |
| tx_req_i | input | 1 | Engine takes a byte to send, one-cycle pulse |
| tx_data_o | output | 8 | Byte to send for the current pointer |
| rf_addr_o | output | 3 | Register-file index (the pointer) |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_rdata_i | input | 8 | Register-file read data at `rf_addr_o` |

## Verification
The assertions check the following on every cycle:
- an acknowledge happens only alongside a received byte;
- the block stays silent after an address mismatch;
- no write strobe reaches index 0, 6 or 7, and indices 6 and 7 read as zero;
- the control register's upper bits do not change between control bytes;
- the pointer changes by exactly one, or not at all, as auto-increment dictates.

The following are shown only by the bench's transfers:
- that the address variant and the direction bit route a transfer correctly;
- that the first write byte lands in the control register and not in the register file;
- the wrap through 6, 7 and 0, in both directions;
- that the pointer survives a repeated start;
- the hold rule for reads that begin at index 0.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CTRL,
    PH_WDATA,
    PH_READ,
    PH_IGNORE
  } phase_e;
endpackage

// File: rtl/i2c_ptr_fsm.sv
module i2c_ptr_fsm
  import i2c_ptr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [6:0]  ADDR7  = 7'b1100010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_req_i,
  output logic              ack_o,
  output logic              ctrl_ld_o,
  output logic              wr_byte_o,
  output logic              rd_byte_o,
  output logic              rd_open_o,
  output logic              ignore_o
);
  phase_e phase_q, phase_d;
  logic   match;

  assign match = (rx_data_i[7:1] == ADDR7);

  always_comb begin
    ack_o     = rx_valid_i && (((phase_q == PH_ADDR) && match) ||
                               (phase_q == PH_CTRL) || (phase_q == PH_WDATA));
    ctrl_ld_o = rx_valid_i && (phase_q == PH_CTRL);
    wr_byte_o = rx_valid_i && (phase_q == PH_WDATA);
    rd_byte_o = tx_req_i && (phase_q == PH_READ);
    rd_open_o = rx_valid_i && (phase_q == PH_ADDR) && match && rx_data_i[0];
    ignore_o  = (phase_q == PH_IGNORE);
  end

  always_comb begin
    phase_d = phase_q;
    if (start_i) begin
      phase_d = PH_ADDR;
    end else if (stop_i) begin
      phase_d = PH_IDLE;
    end else if (rx_valid_i) begin
      unique case (phase_q)
        PH_ADDR: begin
          if (!match)           phase_d = PH_IGNORE;
          else if (rx_data_i[0]) phase_d = PH_READ;
          else                  phase_d = PH_CTRL;
        end
        PH_CTRL: phase_d = PH_WDATA;
        default: phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/i2c_ptr_ctrl.sv
module i2c_ptr_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned AI_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ctrl_ld_i,
  input  logic [DATA_W-1:0] ctrl_wdata_i,
  input  logic              wr_byte_i,
  input  logic              rd_byte_i,
  input  logic              rd_open_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              ai_o,
  output logic              adv_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              hold_q;

  assign ptr_o  = ctrl_q[PTR_W-1:0];
  assign ai_o   = ctrl_q[AI_BIT];
  assign ctrl_o = ctrl_q;
  assign adv_o  = ai_o && (wr_byte_i || (rd_byte_i && !hold_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_ld_i) begin
      ctrl_q <= ctrl_wdata_i;
    end else if (adv_o) begin
      ctrl_q[PTR_W-1:0] <= ctrl_q[PTR_W-1:0] + 1'b1;
    end
  end

  // A read opened at index 0 with auto-increment keeps polling index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= 1'b0;
    else if (start_i)   hold_q <= 1'b0;
    else if (rd_open_i) hold_q <= ai_o && (ptr_o == '0);
  end
endmodule

// File: rtl/i2c_ptr_regs.sv
module i2c_ptr_regs #(
  parameter int unsigned VARIANT  = 0,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PTR_W    = 3,
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned AI_BIT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              ack_o,
  input  logic              tx_req_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [PTR_W-1:0]  rf_addr_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  localparam logic [6:0]       ADDR7    = {6'b110001, VARIANT[0]};
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);
  localparam logic [PTR_W-1:0] RO_IDX   = '0;

  logic              ctrl_ld, wr_byte, rd_byte, rd_open, ignore_bus;
  logic              ptr_adv, ai;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] ctrl_q;
  logic              in_map;

  i2c_ptr_fsm #(.DATA_W(DATA_W), .ADDR7(ADDR7)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .tx_req_i   (tx_req_i),
    .ack_o      (ack_o),
    .ctrl_ld_o  (ctrl_ld),
    .wr_byte_o  (wr_byte),
    .rd_byte_o  (rd_byte),
    .rd_open_o  (rd_open),
    .ignore_o   (ignore_bus)
  );

  i2c_ptr_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W), .AI_BIT(AI_BIT)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .ctrl_ld_i    (ctrl_ld),
    .ctrl_wdata_i (rx_data_i),
    .wr_byte_i    (wr_byte),
    .rd_byte_i    (rd_byte),
    .rd_open_i    (rd_open),
    .ctrl_o       (ctrl_q),
    .ptr_o        (ptr),
    .ai_o         (ai),
    .adv_o        (ptr_adv)
  );

  assign in_map     = (ptr <= LAST_IDX);
  assign rf_addr_o  = ptr;
  assign rf_we_o    = wr_byte && in_map && (ptr != RO_IDX);
  assign rf_wdata_o = rx_data_i;
  assign tx_data_o  = in_map ? rf_rdata_i : '0;
endmodule

// File: rtl/i2c_ptr_regs_chk.sv
module i2c_ptr_regs_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PTR_W    = 3,
  parameter int unsigned NUM_REGS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              ack_o,
  input logic              rf_we_o,
  input logic [PTR_W-1:0]  rf_addr_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              ctrl_ld,
  input logic              ptr_adv,
  input logic              ai,
  input logic              ignore_bus
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> rx_valid_i); // R1
  AST_IGNORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_bus |-> (!ack_o && !rf_we_o)); // R10
  AST_WE_IN_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_addr_o != '0 && rf_addr_o <= LAST_IDX)); // R4
  AST_HIGH_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_addr_o > LAST_IDX) |-> (tx_data_o == '0)); // R8
  AST_UPPER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_ld |=> $stable(ctrl_q[DATA_W-1:PTR_W])); // R6
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_adv && !ctrl_ld) |=> (ctrl_q[PTR_W-1:0] == PTR_W'($past(ctrl_q[PTR_W-1:0]) + 1'b1))); // R5
  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ai && !ctrl_ld) |=> $stable(ctrl_q[PTR_W-1:0])); // R12
endmodule

bind i2c_ptr_regs i2c_ptr_regs_chk #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .ack_o      (ack_o),
  .rf_we_o    (rf_we_o),
  .rf_addr_o  (rf_addr_o),
  .tx_data_o  (tx_data_o),
  .ctrl_q     (ctrl_q),
  .ctrl_ld    (ctrl_ld),
  .ptr_adv    (ptr_adv),
  .ai         (ai),
  .ignore_bus (ignore_bus)
);

// File: tb/i2c_ptr_regs_tb_top.sv
module i2c_ptr_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_data = '0;
  logic       ack_o, rf_we_o;
  logic [7:0] tx_data_o, rf_wdata_o, rf_rdata;
  logic [2:0] rf_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [10:0] wr_q[$];
  string       wr_tag_q[$];
  logic [7:0]  rd_q[$];
  string       rd_tag_q[$];

  always #5 clk = ~clk;

  // Register-file model: in-map index reads A0h+index, out of map drives 5Ah
  assign rf_rdata = (rf_addr_o <= 3'd5) ? (8'hA0 + {5'b0, rf_addr_o}) : 8'h5A;

  i2c_ptr_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .ack_o(ack_o),
    .tx_req_i(tx_req), .tx_data_o(tx_data_o), .rf_addr_o(rf_addr_o),
    .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .rf_rdata_i(rf_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares write strobes and read bytes against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (rf_we_o) begin
        if (wr_q.size() == 0) begin
          chk(1'b0, "R3/R4 unexpected write", {rf_addr_o, rf_wdata_o}, 0);
        end else begin
          logic [10:0] e;
          string t;
          e = wr_q.pop_front();
          t = wr_tag_q.pop_front();
          chk({rf_addr_o, rf_wdata_o} == e, t, {rf_addr_o, rf_wdata_o}, e);
        end
      end
      if (tx_req) begin
        if (rd_q.size() == 0) begin
          chk(1'b0, "R2 unexpected read", tx_data_o, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = rd_q.pop_front();
          t = rd_tag_q.pop_front();
          chk(tx_data_o == e, t, tx_data_o, e);
        end
      end
    end
  end

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    #2 chk(ack_o == exp_ack, tag, ack_o, exp_ack);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic exp_wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    wr_q.push_back({a, d});
    wr_tag_q.push_back(tag);
  endtask

  task automatic read_byte(input logic [7:0] e, input string tag);
    rd_q.push_back(e);
    rd_tag_q.push_back(tag);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic chk_ptr(input logic [2:0] e, input string tag);
    @(negedge clk);
    #2 chk(rf_addr_o == e, tag, rf_addr_o, e);
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    chk_ptr(3'd0, "R7 pointer after reset");
    #1 chk(ack_o == 1'b0, "R7 no ack after reset", ack_o, 0);

    // R1/R10: address of the other variant is refused, following bytes ignored
    do_start();
    send_byte(8'hC6, 1'b0, "R1 mismatched address nack");
    send_byte(8'h11, 1'b0, "R10 byte after mismatch");
    send_byte(8'h22, 1'b0, "R10 second byte after mismatch");
    do_stop();
    chk_ptr(3'd0, "R10 pointer untouched");

    // R3/R4/R5/R8: auto-increment write from index 1 around the wrap
    do_start();
    send_byte(8'hC4, 1'b1, "R1 matched write address");
    send_byte(8'h11, 1'b1, "R3 control byte ack");
    for (int i = 1; i <= 5; i++) exp_wr(3'(i), 8'(8'h10 + i), "R4 write data");
    exp_wr(3'd1, 8'h19, "R5 write after wrap");
    for (int i = 1; i <= 9; i++) send_byte(8'(8'h10 + i), 1'b1, "R4 data ack");
    chk_ptr(3'd2, "R5 pointer after wrap");
    do_stop();

    // R12: no auto-increment
    do_start();
    send_byte(8'hC4, 1'b1, "R2 write address");
    send_byte(8'h03, 1'b1, "R3 control byte no AI");
    exp_wr(3'd3, 8'h33, "R12 first write");
    exp_wr(3'd3, 8'h44, "R12 second write same index");
    send_byte(8'h33, 1'b1, "R12 data ack");
    send_byte(8'h44, 1'b1, "R12 data ack");
    chk_ptr(3'd3, "R12 pointer held");
    do_stop();

    // R6: control starting at 6, flag survives wrap, 6/7/0 dropped
    do_start();
    send_byte(8'hC4, 1'b1, "R2 write address");
    send_byte(8'h16, 1'b1, "R3 control byte index 6");
    exp_wr(3'd1, 8'h64, "R6 write after wrap");
    send_byte(8'h61, 1'b1, "R8 write index 6 ack");
    send_byte(8'h62, 1'b1, "R8 write index 7 ack");
    send_byte(8'h63, 1'b1, "R4 write index 0 ack");
    send_byte(8'h64, 1'b1, "R6 write index 1 ack");
    chk_ptr(3'd2, "R6 flag kept through wrap");
    do_stop();

    // R11/R2/R8: control write, repeated start, auto-increment read
    do_start();
    send_byte(8'hC4, 1'b1, "R2 write address");
    send_byte(8'h12, 1'b1, "R3 control byte index 2");
    do_start();
    send_byte(8'hC5, 1'b1, "R2 read address");
    read_byte(8'hA2, "R11 first read at new index");
    read_byte(8'hA3, "R5 read step");
    read_byte(8'hA4, "R5 read step");
    read_byte(8'hA5, "R5 read step");
    read_byte(8'h00, "R8 index 6 reads zero");
    read_byte(8'h00, "R8 index 7 reads zero");
    read_byte(8'hA0, "R5 read wrap to index 0");
    do_stop();
    chk_ptr(3'd1, "R5 pointer after read wrap");

    // R9: auto-increment read opened at index 0 polls index 0
    do_start();
    send_byte(8'hC4, 1'b1, "R2 write address");
    send_byte(8'h10, 1'b1, "R3 control byte index 0");
    do_start();
    send_byte(8'hC5, 1'b1, "R2 read address");
    read_byte(8'hA0, "R9 hold read 1");
    read_byte(8'hA0, "R9 hold read 2");
    read_byte(8'hA0, "R9 hold read 3");
    do_stop();
    chk_ptr(3'd0, "R9 pointer held at 0");

    repeat (4) @(negedge clk);
    chk(wr_q.size() == 0, "R4 missing writes", wr_q.size(), 0);
    chk(rd_q.size() == 0, "R2 missing reads", rd_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule